// File: doc/BRIEF.md
# Set-Bit Index List Compactor

This block takes a 16-bit vector and returns, in the same evaluation, the positions of all bits that are set, packed side by side as 4-bit indexes. The lowest set position goes into the least significant nibble, the next one into the following nibble, and so on. The sixteen nibble slots together form a 64-bit list. Slots that are not used read as zero.

An index of zero cannot be told apart from an empty slot by its value alone, so a 5-bit count output gives the number of set bits. A consumer such as a multi-port write stage reads the count and takes that many low-order slots as valid.

The block has no clock and no state. Each set bit i computes how many set bits lie below it. That number is the slot that bit i writes its own index into.

Top module: `setbit_compactor`

## Requirements
- R1: For every k below the count, slot k (output bits [4k+3:4k]) holds the bit position of the (k+1)-th lowest set input bit.
- R2: Every slot k at or above the count reads as 4'h0.
- R3: The count output equals the number of set bits in the input, from 0 to 16.
- R4: An all-zero input gives an all-zero list and a count of 0.
- R5: An all-ones input gives the list 64'hfedc_ba98_7654_3210 and a count of 16.
- R6: An input with only bit 0 set gives an all-zero list and a count of 1.
- R7: Input 16'h0035 gives list 64'h5420 with count 4, and input 16'h0a0a gives list 64'hb931 with count 4.
- R8: Both outputs are a pure function of the present input and settle without any clock edge.
- R9: The indexes in the valid slots are strictly increasing from slot 0 upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_i | input | 16 | Vector whose set-bit positions are listed |
| idx_list_o | output | 64 | Sixteen 4-bit index slots, with slot 0 in bits [3:0] |
| set_cnt_o | output | 5 | Number of set bits, which is also the number of valid slots |

## Verification
The bound checker looks at the outputs whenever they change. It checks that the count matches the population of the input and that every slot at or above the count is zero. It also checks that each valid slot points at a bit that is really set, and that the valid indexes rise strictly. These rules allow only one correct list, but the checker does not name any particular result. The exact lists for the example vectors, the all-ones and bit-0-only corners, and the response without a clock edge are shown by the bench's scenarios. The bench also sweeps every one of the 65536 input values against its own behavioural model.

// File: rtl/setbit_pkg.sv
// Shared sizing for the set-bit compactor.
// Assumes the vector width is a power of two, so that one index fills its slot exactly.
package setbit_pkg;
    localparam int VEC_W = 16;
    localparam int IDX_W = $clog2(VEC_W);
    localparam int CNT_W = $clog2(VEC_W + 1);
endpackage

// File: rtl/setbit_prefix.sv
// Exclusive prefix population counter.
// For each bit i it gives the number of set bits strictly below i. It also gives the total count.
// Assumes a purely combinational context. Each bit has its own parallel count tree, with no ripple chain between bits.
module setbit_prefix #(
    parameter int VEC_W = setbit_pkg::VEC_W,
    localparam int CNT_W = $clog2(VEC_W + 1)
) (
    input  logic [VEC_W-1:0]       vec_i,
    output logic [VEC_W*CNT_W-1:0] below_o,
    output logic [CNT_W-1:0]       total_o
);

    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        localparam logic [VEC_W-1:0] LOW_MASK = (VEC_W'(1) << i) - VEC_W'(1);
        // Counts the set bits under position i.
        assign below_o[i*CNT_W +: CNT_W] = CNT_W'($countones(vec_i & LOW_MASK));
    end

    // Total: the count below the top bit, plus the top bit itself.
    assign total_o = below_o[(VEC_W-1)*CNT_W +: CNT_W] + CNT_W'(vec_i[VEC_W-1]);

endmodule

// File: rtl/setbit_scatter.sv
// Slot scatter network.
// Each set bit i writes index i into the slot named by its prefix count. Unclaimed slots stay zero.
// Assumes the prefix counts come from setbit_prefix, so no two set bits ever claim the same slot.
module setbit_scatter #(
    parameter int VEC_W = setbit_pkg::VEC_W,
    localparam int IDX_W = $clog2(VEC_W),
    localparam int CNT_W = $clog2(VEC_W + 1)
) (
    input  logic [VEC_W-1:0]       vec_i,
    input  logic [VEC_W*CNT_W-1:0] below_i,
    output logic [VEC_W*IDX_W-1:0] list_o
);

    for (genvar s = 0; s < VEC_W; s++) begin : g_slot
        logic [IDX_W-1:0] acc;
        // ORs together the index of whichever set bit targets slot s.
        always_comb begin
            acc = '0;
            for (int i = 0; i < VEC_W; i++) begin
                if (vec_i[i] && (below_i[i*CNT_W +: CNT_W] == CNT_W'(s))) begin
                    acc = acc | IDX_W'(i);
                end
            end
        end
        assign list_o[s*IDX_W +: IDX_W] = acc;
    end

endmodule

// File: rtl/setbit_compactor.sv
// Set-bit index list compactor, top level.
// Lists every set bit position in ascending order, packed from slot 0 upward, and gives the number of valid slots.
// Assumes a combinational use: no clock, no reset and no state.
module setbit_compactor #(
    parameter int VEC_W = setbit_pkg::VEC_W,
    localparam int IDX_W = $clog2(VEC_W),
    localparam int CNT_W = $clog2(VEC_W + 1)
) (
    input  logic [VEC_W-1:0]       vec_i,
    output logic [VEC_W*IDX_W-1:0] idx_list_o,
    output logic [CNT_W-1:0]       set_cnt_o
);

    logic [VEC_W*CNT_W-1:0] below;

    // Computes the rank of each bit among the set bits.
    setbit_prefix #(.VEC_W(VEC_W)) u_prefix (
        .vec_i  (vec_i),
        .below_o(below),
        .total_o(set_cnt_o)
    );

    // Places each set bit's index into its ranked slot.
    setbit_scatter #(.VEC_W(VEC_W)) u_scatter (
        .vec_i  (vec_i),
        .below_i(below),
        .list_o (idx_list_o)
    );

endmodule

// File: rtl/setbit_compactor_chk.sv
// Property checker for setbit_compactor, attached to it with a bind statement.
// Checks the structural rules of the list each time the ports change.
module setbit_compactor_chk #(
    parameter int VEC_W = setbit_pkg::VEC_W,
    localparam int IDX_W = $clog2(VEC_W),
    localparam int CNT_W = $clog2(VEC_W + 1)
) (
    input logic [VEC_W-1:0]       vec_i,
    input logic [VEC_W*IDX_W-1:0] list_i,
    input logic [CNT_W-1:0]       cnt_i
);

    // Checks the count against the input population, then checks each slot.
    always_comb begin
        AST_CNT_POP: assert (int'(cnt_i) == $countones(vec_i)) else $error("count mismatch"); // R3
        AST_ZERO_IN: assert ((vec_i != '0) || ((list_i == '0) && (cnt_i == '0))) else $error("zero input"); // R4
        for (int k = 0; k < VEC_W; k++) begin
            if (k >= int'(cnt_i)) begin
                AST_EMPTY_SLOT: assert (list_i[k*IDX_W +: IDX_W] == '0) else $error("empty slot"); // R2
            end else begin
                AST_SLOT_SET: assert (vec_i[list_i[k*IDX_W +: IDX_W]]) else $error("slot not set"); // R1
                if (k > 0) begin
                    AST_ASCEND: assert (list_i[k*IDX_W +: IDX_W] > list_i[(k-1)*IDX_W +: IDX_W]) else $error("order"); // R9
                end
            end
        end
    end

endmodule

bind setbit_compactor setbit_compactor_chk #(.VEC_W(VEC_W)) u_chk (
    .vec_i (vec_i),
    .list_i(idx_list_o),
    .cnt_i (set_cnt_o)
);

// File: tb/sim_setbit_compactor.sv
module sim_setbit_compactor;
    localparam int VW = setbit_pkg::VEC_W;
    localparam int IW = setbit_pkg::IDX_W;
    localparam int CW = setbit_pkg::CNT_W;

    logic clk = 1'b0;
    logic [VW-1:0] vec;
    logic [VW*IW-1:0] lst;
    logic [CW-1:0] cnt;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    setbit_compactor u0 (.vec_i(vec), .idx_list_o(lst), .set_cnt_o(cnt));

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Behavioural reference: collect the set positions in a queue, then pack them.
    function automatic void ref_model(input logic [VW-1:0] v, output logic [VW*IW-1:0] l, output int c);
        int q[$];
        l = '0;
        for (int i = 0; i < VW; i++) if (v[i]) q.push_back(i);
        foreach (q[j]) l[j*IW +: IW] = IW'(q[j]);
        c = q.size();
    endfunction

    task automatic apply_and_compare(input logic [VW-1:0] v, input string tag);
        logic [VW*IW-1:0] el;
        int ec;
        @(posedge clk);
        vec = v;
        @(negedge clk);
        ref_model(v, el, ec);
        chk({tag, " R1 list"}, 64'(lst), 64'(el));
        chk({tag, " R3 count"}, 64'(cnt), 64'(ec));
    endtask

    initial begin
        vec = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R4 idle list", 64'(lst), 64'h0);
        chk("R4 idle count", 64'(cnt), 64'd0);
        // R5 all ones
        apply_and_compare('1, "R5");
        chk("R5 list", 64'(lst), 64'hfedc_ba98_7654_3210);
        chk("R5 count", 64'(cnt), 64'd16);
        // R6 only bit 0
        apply_and_compare(16'h0001, "R6");
        chk("R6 list", 64'(lst), 64'h0);
        chk("R6 count", 64'(cnt), 64'd1);
        // R7 examples
        apply_and_compare(16'h0035, "R7a");
        chk("R7 list 0035", 64'(lst), 64'h5420);
        apply_and_compare(16'h0a0a, "R7b");
        chk("R7 list 0a0a", 64'(lst), 64'hb931);
        chk("R7 count 0a0a", 64'(cnt), 64'd4);
        // R2 only top bit: slot 0 holds f, others zero
        apply_and_compare(16'h8000, "R2");
        chk("R2 top only", 64'(lst), 64'hf);
        // R8 change without any clock edge
        @(negedge clk);
        vec = 16'h8421;
        #1;
        chk("R8 no-clock list", 64'(lst), 64'hfa50);
        chk("R8 no-clock count", 64'(cnt), 64'd4);
        // R9 ascending order for alternating bits
        apply_and_compare(16'haaaa, "R9");
        chk("R9 list aaaa", 64'(lst), 64'h0000_0000_fdb9_7531);
        // Exhaustive sweep over all input values (R1 R2 R3)
        for (int v = 0; v < (1 << VW); v++) begin
            apply_and_compare(VW'(v), "sweep");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule